// File: doc/BRIEF.md
# ATA Status Error Classifier

This block sits beside the host-side protocol state machine of an ATA/ATAPI port. Each time the state machine reads the device Status and Error registers, it raises a sample strobe and reports the command phase that the port is in. The block decides whether that observation is abnormal. If it is, the block sorts it into one error category and gives recovery advice: reset the link, slow the transfer down, fetch sense data, or read the queued-command error log. The same register bits mean different things in different phases. Error with Busy clear is a protocol violation while the command packet is still going out, a CHECK CONDITION once the packet is complete, and a queued-command error while native queued commands are outstanding.

The recovery engine reports a failed error-log read on a separate strobe. The block then escalates that failure to a protocol violation. Every verdict is registered and appears one clock after the strobe that caused it. A normal observation produces no verdict, so the consumer only has to act on the valid pulse.

Top module: `ata_err_classifier`

## Requirements
- R1: A verdict appears exactly one clock after the sample or log-fail strobe: `verdict_valid_o` is high for that one cycle, and only when the observation is abnormal. While it is low, the category vector and all four advice outputs are zero. All outputs are zero after reset. Category bit positions are: 0 protocol violation, 1 bus error, 2 media error, 3 address error, 4 device error, 5 CHECK CONDITION, 6 queued-command error. A verdict carries exactly one category bit.
- R2: Phase 0 (before issue): any Status other than Busy (bit 7) clear, Ready (bit 6) set and Data-request (bit 3) clear is a protocol violation.
- R3: Phase 1 (PIO data transfer): with Busy clear, Data-request clear is a protocol violation, even when Error (Status bit 0) is set. With Busy clear, Data-request set and Error set, the observation goes to the Error-register decode (R8).
- R4: Phase 3 (command packet being sent): Error set with Busy clear is a protocol violation.
- R5: Phase 2 (just after the PACKET command is issued): Error with Abort (Error bit 2) and Busy clear is a device error (unsupported command). Error without Abort goes to the Error-register decode.
- R6: Phase 4 (after the last packet byte): Error with Busy clear is CHECK CONDITION and raises `sense_req_o`, whatever the Error register holds.
- R7: Phase 5 (completion): with Busy clear, Data-request set is a protocol violation. Otherwise Error set goes to the Error-register decode.
- R8: The Error-register decode takes the first match in this order: interface CRC (bit 7) gives a bus error, uncorrectable (bit 6) gives a media error, ID-not-found (bit 4) gives an address error, and anything else (Abort or no bit at all) gives a device error.
- R9: Phase 6 (queued commands outstanding): Error with Busy clear is a queued-command error and raises `log_req_o`.
- R10: A log-fail strobe gives a protocol violation. It takes priority over a sample taken in the same cycle.
- R11: `reset_rec_o` is high exactly when the verdict is a protocol violation. `slow_rec_o` is high exactly for a protocol violation or a bus error.
- R12: In phases 1 through 6, Busy set gives no verdict. Phase 7 never gives a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Status/Error values and phase are valid this cycle |
| phase_i | input | 3 | Command phase, encoding as in R2 to R9 and R12 |
| status_i | input | 8 | Device Status register value |
| error_i | input | 8 | Device Error register value |
| log_fail_i | input | 1 | The queued-command error-log read failed |
| verdict_valid_o | output | 1 | One-cycle verdict strobe |
| category_o | output | 7 | One-hot error category |
| reset_rec_o | output | 1 | Reset recommended |
| slow_rec_o | output | 1 | Lower transfer speed recommended |
| sense_req_o | output | 1 | Sense data must be fetched |
| log_req_o | output | 1 | Error log must be read |

## Verification
Every output of this block is due on the first rising edge after the strobe that caused it. There is no later result and no result on any other cycle. The driver applies one observation per falling edge and queues one expected verdict per driven cycle, including a zero verdict for idle cycles. The monitor takes one entry from the queue a short time after each rising edge and compares it. Back-to-back strobes therefore check that each verdict lines up with its own cycle, and idle cycles check that the pulse lasts exactly one cycle.

// File: rtl/ata_cls_pkg.sv
package ata_cls_pkg;

  localparam int REG_W     = 8;
  localparam int PHASE_W   = 3;
  localparam int NUM_CAT   = 7;
  localparam int CAT_IDX_W = $clog2(NUM_CAT + 1);

  // Status register bit positions
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  // Error register bit positions
  localparam int ER_ICRC = 7;
  localparam int ER_UNC  = 6;
  localparam int ER_IDNF = 4;
  localparam int ER_ABRT = 2;

  // Category indices into the one-hot vector
  localparam int CAT_HSM   = 0;
  localparam int CAT_BUS   = 1;
  localparam int CAT_MEDIA = 2;
  localparam int CAT_ADDR  = 3;
  localparam int CAT_DEV   = 4;
  localparam int CAT_CHECK = 5;
  localparam int CAT_NCQ   = 6;
  localparam int CAT_NONE  = NUM_CAT;

  typedef enum logic [PHASE_W-1:0] {
    PH_PRE     = 3'd0,
    PH_PIO     = 3'd1,
    PH_PKT     = 3'd2,
    PH_CDB     = 3'd3,
    PH_POSTCDB = 3'd4,
    PH_DONE    = 3'd5,
    PH_NCQ     = 3'd6,
    PH_RSVD    = 3'd7
  } phase_e;

  typedef struct packed {
    logic hsm;
    logic chk;
    logic ncq;
    logic unsup;
    logic decode;
  } rule_t;

endpackage

// File: rtl/ata_phase_rules.sv
module ata_phase_rules
  import ata_cls_pkg::*;
(
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [REG_W-1:0]   status_i,
  input  logic               abrt_i,
  output rule_t              rule_o
);

  logic bsy, drdy, drq, err;

  always_comb begin
    bsy  = status_i[ST_BSY];
    drdy = status_i[ST_DRDY];
    drq  = status_i[ST_DRQ];
    err  = status_i[ST_ERR];
    rule_o = '0;
    case (phase_e'(phase_i))
      PH_PRE: begin
        rule_o.hsm = bsy | ~drdy | drq;
      end
      PH_PIO: begin
        if (!bsy) begin
          rule_o.hsm    = ~drq;
          rule_o.decode = drq & err;
        end
      end
      PH_PKT: begin
        if (!bsy && err) begin
          rule_o.unsup  = abrt_i;
          rule_o.decode = ~abrt_i;
        end
      end
      PH_CDB: begin
        rule_o.hsm = ~bsy & err;
      end
      PH_POSTCDB: begin
        rule_o.chk = ~bsy & err;
      end
      PH_DONE: begin
        if (!bsy) begin
          rule_o.hsm    = drq;
          rule_o.decode = ~drq & err;
        end
      end
      PH_NCQ: begin
        rule_o.ncq = ~bsy & err;
      end
      default: rule_o = '0;
    endcase
  end

endmodule

// File: rtl/ata_err_decode.sv
module ata_err_decode
  import ata_cls_pkg::*;
(
  input  logic [REG_W-1:0]     error_i,
  output logic [CAT_IDX_W-1:0] idx_o
);

  always_comb begin
    if (error_i[ER_ICRC])      idx_o = CAT_IDX_W'(CAT_BUS);
    else if (error_i[ER_UNC])  idx_o = CAT_IDX_W'(CAT_MEDIA);
    else if (error_i[ER_IDNF]) idx_o = CAT_IDX_W'(CAT_ADDR);
    else                       idx_o = CAT_IDX_W'(CAT_DEV);
  end

endmodule

// File: rtl/ata_verdict_reg.sv
module ata_verdict_reg
  import ata_cls_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire_i,
  input  logic [CAT_IDX_W-1:0] sel_i,
  output logic                 valid_o,
  output logic [NUM_CAT-1:0]   cat_o,
  output logic                 reset_rec_o,
  output logic                 slow_rec_o,
  output logic                 sense_o,
  output logic                 log_o
);

  logic               hit;
  logic [NUM_CAT-1:0] cat_d;
  logic               valid_d, reset_d, slow_d, sense_d, log_d;

  assign hit = fire_i && (sel_i != CAT_IDX_W'(CAT_NONE));

  genvar g;
  generate
    for (g = 0; g < NUM_CAT; g++) begin : g_onehot
      assign cat_d[g] = hit && (sel_i == CAT_IDX_W'(g));
    end
  endgenerate

  always_comb begin
    valid_d = hit;
    reset_d = cat_d[CAT_HSM];
    slow_d  = cat_d[CAT_HSM] | cat_d[CAT_BUS];
    sense_d = cat_d[CAT_CHECK];
    log_d   = cat_d[CAT_NCQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o     <= 1'b0;
      cat_o       <= '0;
      reset_rec_o <= 1'b0;
      slow_rec_o  <= 1'b0;
      sense_o     <= 1'b0;
      log_o       <= 1'b0;
    end else begin
      valid_o     <= valid_d;
      cat_o       <= cat_d;
      reset_rec_o <= reset_d;
      slow_rec_o  <= slow_d;
      sense_o     <= sense_d;
      log_o       <= log_d;
    end
  end

endmodule

// File: rtl/ata_err_classifier.sv
module ata_err_classifier
  import ata_cls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [REG_W-1:0]   status_i,
  input  logic [REG_W-1:0]   error_i,
  input  logic               log_fail_i,
  output logic               verdict_valid_o,
  output logic [NUM_CAT-1:0] category_o,
  output logic               reset_rec_o,
  output logic               slow_rec_o,
  output logic               sense_req_o,
  output logic               log_req_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  rule_t                rule;
  logic [CAT_IDX_W-1:0] dec_idx;
  logic [CAT_IDX_W-1:0] sel;
  logic                 fire;

  ata_phase_rules i_rules (
    .phase_i  (phase_i),
    .status_i (status_i),
    .abrt_i   (error_i[ER_ABRT]),
    .rule_o   (rule)
  );

  ata_err_decode i_decode (
    .error_i (error_i),
    .idx_o   (dec_idx)
  );

  // Priority: log failure, protocol violation, phase-specific verdicts, decode
  always_comb begin
    fire = sample_i | log_fail_i;
    if (log_fail_i)        sel = CAT_IDX_W'(CAT_HSM);
    else if (rule.hsm)     sel = CAT_IDX_W'(CAT_HSM);
    else if (rule.chk)     sel = CAT_IDX_W'(CAT_CHECK);
    else if (rule.ncq)     sel = CAT_IDX_W'(CAT_NCQ);
    else if (rule.unsup)   sel = CAT_IDX_W'(CAT_DEV);
    else if (rule.decode)  sel = dec_idx;
    else                   sel = CAT_IDX_W'(CAT_NONE);
  end

  ata_verdict_reg i_verdict (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .fire_i      (fire),
    .sel_i       (sel),
    .valid_o     (verdict_valid_o),
    .cat_o       (category_o),
    .reset_rec_o (reset_rec_o),
    .slow_rec_o  (slow_rec_o),
    .sense_o     (sense_req_o),
    .log_o       (log_req_o)
  );

endmodule

// File: rtl/ata_err_classifier_chk.sv
module ata_err_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_i,
  input logic [2:0] phase_i,
  input logic [7:0] status_i,
  input logic [7:0] error_i,
  input logic       log_fail_i,
  input logic       verdict_valid_o,
  input logic [6:0] category_o,
  input logic       reset_rec_o,
  input logic       slow_rec_o,
  input logic       sense_req_o,
  input logic       log_req_o
);

  a_r1_single_cat: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid_o |-> ($countones(category_o) == 1));

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid_o |-> (category_o == 7'd0 && !reset_rec_o && !slow_rec_o
                          && !sense_req_o && !log_req_o));

  a_r1_caused: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid_o |-> $past(sample_i || log_fail_i));

  a_r2_busy_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && phase_i == 3'd0 && status_i[7]) |=> (verdict_valid_o && category_o[0]));

  a_r4_early_err: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && phase_i == 3'd3 && !status_i[7] && status_i[0]) |=> category_o[0]);

  a_r6_sense: assert property (@(posedge clk) disable iff (!rst_n)
    sense_req_o |-> category_o[5]);

  a_r9_log: assert property (@(posedge clk) disable iff (!rst_n)
    log_req_o |-> category_o[6]);

  a_r10_logfail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_fail_i) |=> (verdict_valid_o && category_o[0]));

  a_r11_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_rec_o == (verdict_valid_o && category_o[0]));

  a_r11_slow: assert property (@(posedge clk) disable iff (!rst_n)
    slow_rec_o == (verdict_valid_o && (category_o[0] || category_o[1])));

  a_r12_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !log_fail_i && phase_i == 3'd7) |=> !verdict_valid_o);

  logic unused_ok;
  assign unused_ok = ^error_i;

endmodule

bind ata_err_classifier ata_err_classifier_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sample_i        (sample_i),
  .phase_i         (phase_i),
  .status_i        (status_i),
  .error_i         (error_i),
  .log_fail_i      (log_fail_i),
  .verdict_valid_o (verdict_valid_o),
  .category_o      (category_o),
  .reset_rec_o     (reset_rec_o),
  .slow_rec_o      (slow_rec_o),
  .sense_req_o     (sense_req_o),
  .log_req_o       (log_req_o)
);

// File: tb/test_ata_err_classifier.sv
`timescale 1ns/1ps
module test_ata_err_classifier;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_i = 1'b0;
  logic [2:0] phase_i = 3'd0;
  logic [7:0] status_i = 8'd0;
  logic [7:0] error_i = 8'd0;
  logic       log_fail_i = 1'b0;
  logic       verdict_valid_o;
  logic [6:0] category_o;
  logic       reset_rec_o, slow_rec_o, sense_req_o, log_req_o;

  int checks = 0;
  int fails  = 0;

  logic [11:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  ata_err_classifier i_ata_err_classifier (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .phase_i(phase_i),
    .status_i(status_i), .error_i(error_i), .log_fail_i(log_fail_i),
    .verdict_valid_o(verdict_valid_o), .category_o(category_o),
    .reset_rec_o(reset_rec_o), .slow_rec_o(slow_rec_o),
    .sense_req_o(sense_req_o), .log_req_o(log_req_o)
  );

  // Expected verdict packed as {valid, cat[6:0], reset, slow, sense, log}
  function automatic logic [11:0] pack_cat(input int c);
    logic [6:0] v;
    if (c < 0) return 12'd0;
    v = 7'd1 << c;
    return {1'b1, v, c == 0, (c == 0) || (c == 1), c == 5, c == 6};
  endfunction

  function automatic int decode_err(input logic [7:0] e);
    if (e[7]) return 1;
    if (e[6]) return 2;
    if (e[4]) return 3;
    return 4;
  endfunction

  function automatic logic [11:0] model(input logic s, input logic [2:0] ph,
                                        input logic [7:0] st, input logic [7:0] er,
                                        input logic lf);
    int c;
    logic busy, rdy, dreq, err;
    busy = st[7]; rdy = st[6]; dreq = st[3]; err = st[0];
    c = -1;
    if (lf) c = 0;
    else if (s) begin
      case (ph)
        3'd0: if (busy || !rdy || dreq) c = 0;
        3'd1: if (!busy) begin
                if (!dreq) c = 0;
                else if (err) c = decode_err(er);
              end
        3'd2: if (!busy && err) c = er[2] ? 4 : decode_err(er);
        3'd3: if (!busy && err) c = 0;
        3'd4: if (!busy && err) c = 5;
        3'd5: if (!busy) begin
                if (dreq) c = 0;
                else if (err) c = decode_err(er);
              end
        3'd6: if (!busy && err) c = 6;
        default: c = -1;
      endcase
    end
    return pack_cat(c);
  endfunction

  // Driver: one observation per falling edge, one expectation per driven cycle
  task automatic drive(input string tag, input logic s, input logic [2:0] ph,
                       input logic [7:0] st, input logic [7:0] er, input logic lf);
    @(negedge clk);
    sample_i = s; phase_i = ph; status_i = st; error_i = er; log_fail_i = lf;
    q_exp.push_back(model(s, ph, st, er, lf));
    q_tag.push_back(tag);
  endtask

  task automatic obs(input string tag, input logic [2:0] ph,
                     input logic [7:0] st, input logic [7:0] er);
    drive(tag, 1'b1, ph, st, er, 1'b0);
    drive({tag, "_idle"}, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0);
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [11:0] e, a;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = {verdict_valid_o, category_o, reset_rec_o, slow_rec_o, sense_req_o, log_req_o};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if ({verdict_valid_o, category_o, reset_rec_o, slow_rec_o, sense_req_o, log_req_o} !== 12'd0) begin
      fails++;
      $display("FAIL R1 reset: actual %b expected 0", verdict_valid_o);
    end

    // R2 before issue
    obs("R2_ok",   3'd0, 8'h50, 8'h00);
    obs("R2_bsy",  3'd0, 8'h80, 8'h00);
    obs("R2_nrdy", 3'd0, 8'h00, 8'h00);
    obs("R2_drq",  3'd0, 8'h58, 8'h00);
    // R3 PIO transfer
    obs("R3_ok",     3'd1, 8'h58, 8'h00);
    obs("R3_nodrq",  3'd1, 8'h50, 8'h00);
    obs("R3_err",    3'd1, 8'h59, 8'h40);
    obs("R3_errhsm", 3'd1, 8'h51, 8'h04);
    // R4 packet being sent
    obs("R4_err", 3'd3, 8'h51, 8'h00);
    obs("R4_ok",  3'd3, 8'h58, 8'h00);
    // R5 just after PACKET issue
    obs("R5_unsup",  3'd2, 8'h51, 8'h04);
    obs("R5_crc",    3'd2, 8'h51, 8'h80);
    obs("R5_crcabt", 3'd2, 8'h51, 8'h84);
    // R6 after last packet byte
    obs("R6_abrt", 3'd4, 8'h51, 8'h04);
    obs("R6_none", 3'd4, 8'h51, 8'h00);
    obs("R6_crc",  3'd4, 8'h51, 8'h80);
    // R7 completion
    obs("R7_drq",  3'd5, 8'h58, 8'h00);
    obs("R7_idnf", 3'd5, 8'h51, 8'h10);
    obs("R7_ok",   3'd5, 8'h50, 8'h00);
    // R8 decode priority
    obs("R8_all",  3'd5, 8'h51, 8'hD4);
    obs("R8_unc",  3'd5, 8'h51, 8'h54);
    obs("R8_idnf", 3'd5, 8'h51, 8'h14);
    obs("R8_abrt", 3'd5, 8'h51, 8'h04);
    obs("R8_zero", 3'd5, 8'h51, 8'h00);
    // R9 queued commands
    obs("R9_err", 3'd6, 8'h41, 8'h04);
    obs("R9_ok",  3'd6, 8'h40, 8'h00);
    // R10 log-read failure
    drive("R10_alone", 1'b0, 3'd0, 8'h00, 8'h00, 1'b1);
    drive("R10_idle",  1'b0, 3'd0, 8'h00, 8'h00, 1'b0);
    drive("R10_both",  1'b1, 3'd6, 8'h41, 8'h00, 1'b1);
    drive("R10_idle2", 1'b0, 3'd0, 8'h00, 8'h00, 1'b0);
    // R12 busy and reserved phase
    obs("R12_bsy",  3'd1, 8'hD1, 8'h04);
    obs("R12_bsy6", 3'd6, 8'hC1, 8'h00);
    obs("R12_rsvd", 3'd7, 8'h51, 8'h04);
    // R1 R11 back-to-back verdicts
    drive("R11_hsm",  1'b1, 3'd3, 8'h51, 8'h00, 1'b0);
    drive("R11_bus",  1'b1, 3'd5, 8'h51, 8'h80, 1'b0);
    drive("R11_med",  1'b1, 3'd5, 8'h51, 8'h40, 1'b0);
    drive("R1_none",  1'b1, 3'd0, 8'h50, 8'h00, 1'b0);
    drive("R1_chk",   1'b1, 3'd4, 8'h51, 8'h00, 1'b0);
    drive("R1_idle",  1'b0, 3'd0, 8'h00, 8'h00, 1'b0);
    drive("R1_idle2", 1'b0, 3'd0, 8'h00, 8'h00, 1'b0);

    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule